// File: doc/BRIEF.md
# Alarm Match and Event Interrupt

This block decides when a real-time clock raises its alarm and update events. On every one-second update strobe it compares four running time bytes (seconds, minutes, hours, day of month) with four alarm bytes. When every field agrees, or the alarm byte holds a wildcard code, it sets an alarm event flag. Every update strobe also sets an update-done event flag.

The flags are sticky. A one-cycle status-read strobe clears them, and during that cycle the flag outputs still show the values held before the clear. The interrupt request models an open-drain, active-low line as an enable for a low driver. The enable is high whenever a flag is set and its enable bit is also set. The time counters, the bus interface, periodic interrupts and clock dividers belong to other blocks.

Top module: `alarm_irq`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is 0 and `irq_drive_o` is 0.
- R2: Every cycle with `upd_done_i` high sets the update flag, `flags_o[1]`, at the next clock edge.
- R3: In a cycle with `upd_done_i` high, if all four alarm fields match their time fields, the alarm flag `flags_o[0]` sets at the next edge. This holds across the full day-of-month range 1 to 31.
- R4: The alarm flag never sets in a cycle without `upd_done_i`, even when every field matches.
- R5: An alarm byte whose bits [7:6] are both 1 (0xC0 to 0xFF) matches any time value in that field.
- R6: A mismatch in any single field, with the other three matching, keeps the alarm flag clear.
- R7: `irq_drive_o` is high exactly when `flags_o & en_i` is nonzero. `en_i[0]` enables the alarm event and `en_i[1]` enables the update event, and the output follows `en_i` without a clock delay.
- R8: During a cycle with `stat_rd_i` high, `flags_o` shows the flags held before the read. If no update strobe occurs in that cycle, the next edge clears all flags and releases `irq_drive_o`.
- R9: When `stat_rd_i` and `upd_done_i` are high in the same cycle, the read clears the old flags and the events of that update are kept.
- R10: Flags stay set across later updates until a status read, even if the alarm no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_done_i | input | 1 | One-cycle strobe at the end of the one-second update |
| time_i | input | 32 | Time bytes: [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] day of month |
| alm_i | input | 32 | Alarm bytes, same field layout as `time_i` |
| en_i | input | 2 | Event enables: bit 0 alarm, bit 1 update |
| stat_rd_i | input | 1 | One-cycle status-register read strobe |
| flags_o | output | 2 | Event flags: bit 0 alarm, bit 1 update |
| irq_drive_o | output | 1 | Enables the low driver of the interrupt line |

## Verification
The day-of-month alarm is swept against every day-of-month time from 1 to 31. Only the diagonal may raise the alarm, which separates equality from near misses. For each field in turn, all 64 wildcard codes are tried against varying time values, and a single-field off-by-one mismatch is tried, so each field's compare is checked on its own. Matching time without a strobe, sticky flags across a later mismatch, a read coinciding with an update, and each enable pattern tell the event sequencing apart from the compare logic.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned FLD_W   = 8;
  localparam int unsigned NFLD    = 4;
  localparam int unsigned NEV     = 2;
  localparam int unsigned EV_ALM  = 0;
  localparam int unsigned EV_UPD  = 1;
  localparam logic [1:0]  WILD_TOP = 2'b11;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] time_fld_i,
  input  logic [W-1:0] alm_fld_i,
  output logic         match_o
);
  import alarm_irq_pkg::*;
  logic wild;
  assign wild    = (alm_fld_i[W-1 -: 2] == WILD_TOP);
  assign match_o = wild || (alm_fld_i == time_fld_i);
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4,
  localparam int unsigned BUS_W = W * N
) (
  input  logic [BUS_W-1:0] time_i,
  input  logic [BUS_W-1:0] alm_i,
  output logic             all_match_o
);
  logic [N-1:0] fld_match;

  for (genvar g = 0; g < N; g++) begin : g_fld
    alarm_field_cmp #(.W(W)) u_cmp (
      .time_fld_i (time_i[g*W +: W]),
      .alm_fld_i  (alm_i[g*W +: W]),
      .match_o    (fld_match[g])
    );
  end

  assign all_match_o = &fld_match;
endmodule

// File: rtl/event_flags.sv
module event_flags #(
  parameter int unsigned NEV = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] set_i,
  input  logic           clr_i,
  output logic [NEV-1:0] flags_o
);
  logic [NEV-1:0] flags_q;

  // set wins over clear so an event in the read cycle is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq
  import alarm_irq_pkg::*;
#(
  parameter int unsigned W = FLD_W,
  parameter int unsigned N = NFLD,
  localparam int unsigned BUS_W = W * N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_done_i,
  input  logic [BUS_W-1:0] time_i,
  input  logic [BUS_W-1:0] alm_i,
  input  logic [NEV-1:0]   en_i,
  input  logic             stat_rd_i,
  output logic [NEV-1:0]   flags_o,
  output logic             irq_drive_o
);
  logic           all_match;
  logic [NEV-1:0] ev_set;
  logic [NEV-1:0] flags;

  alarm_match #(.W(W), .N(N)) u_match (
    .time_i      (time_i),
    .alm_i       (alm_i),
    .all_match_o (all_match)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_UPD] = upd_done_i;
    ev_set[EV_ALM] = upd_done_i & all_match;
  end

  event_flags #(.NEV(NEV)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (ev_set),
    .clr_i   (stat_rd_i),
    .flags_o (flags)
  );

  assign flags_o     = flags;
  assign irq_drive_o = |(flags & en_i);
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
  import alarm_irq_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_done_i,
  input logic [BUS_W-1:0] time_i,
  input logic [BUS_W-1:0] alm_i,
  input logic [NEV-1:0]   en_i,
  input logic             stat_rd_i,
  input logic [NEV-1:0]   flags_o,
  input logic             irq_drive_o
);
  p_upd_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> flags_o[EV_UPD]);

  p_alarm_on_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[EV_ALM]) |-> $past(upd_done_i));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !upd_done_i) |=> (flags_o == '0 && !irq_drive_o));

  p_sticky_alm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[EV_ALM] && !stat_rd_i) |=> flags_o[EV_ALM]);

  p_sticky_upd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[EV_UPD] && !stat_rd_i) |=> flags_o[EV_UPD]);

  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_drive_o |-> (flags_o != '0));
endmodule

bind alarm_irq alarm_irq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_done_i  (upd_done_i),
  .time_i      (time_i),
  .alm_i       (alm_i),
  .en_i        (en_i),
  .stat_rd_i   (stat_rd_i),
  .flags_o     (flags_o),
  .irq_drive_o (irq_drive_o)
);

// File: tb/sim_alarm_irq.sv
`timescale 1ns/1ps
module sim_alarm_irq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  en = 2'b00;
  logic [7:0]  tm [4];
  logic [7:0]  al [4];
  logic [31:0] time_v, alm_v;
  logic [1:0]  flags;
  logic        irq;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  assign time_v = {tm[3], tm[2], tm[1], tm[0]};
  assign alm_v  = {al[3], al[2], al[1], al[0]};

  always #4 clk = ~clk;

  alarm_irq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .upd_done_i(upd), .time_i(time_v),
    .alm_i(alm_v), .en_i(en), .stat_rd_i(rd), .flags_o(flags), .irq_drive_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit fld_ok(input logic [7:0] a, input logic [7:0] t);
    return (a >= 8'hC0) || (a == t);
  endfunction

  function automatic bit exp_alarm();
    bit m = 1'b1;
    for (int f = 0; f < 4; f++) m &= fld_ok(al[f], tm[f]);
    return m;
  endfunction

  task automatic upd_pulse();
    @(negedge clk) upd = 1'b1;
    @(negedge clk) upd = 1'b0;
  endtask

  task automatic rd_pulse(input logic [1:0] pre, input string req);
    @(negedge clk) rd = 1'b1;
    #1 chk(flags == pre, req, flags, pre);
    @(negedge clk) rd = 1'b0;
    chk(flags == 2'b00, req, flags, 0);
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] d);
    tm[0] = s; tm[1] = m; tm[2] = h; tm[3] = d;
    al[0] = s; al[1] = m; al[2] = h; al[3] = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] e;
    set_all(8'h10, 8'h20, 8'h05, 8'h01);
    tm[0] = 8'h11;
    repeat (3) @(negedge clk);
    upd = 1'b1;
    #1 chk(flags == 2'b00 && irq == 1'b0, "R1", {irq, flags}, 0);
    @(negedge clk) upd = 1'b0;
    chk(flags == 2'b00, "R1", flags, 0);
    rst_ni = 1'b1;

    // R2, R7: update flag and enables
    upd_pulse();
    chk(flags == 2'b10, "R2", flags, 2'b10);
    chk(irq == 1'b0, "R7", irq, 0);
    en = 2'b10; #1 chk(irq == 1'b1, "R7", irq, 1);
    en = 2'b01; #1 chk(irq == 1'b0, "R7", irq, 0);
    en = 2'b10;
    rd_pulse(2'b10, "R8");
    chk(irq == 1'b0, "R8", irq, 0);

    // R4: matching time without strobe
    set_all(8'h30, 8'h15, 8'h07, 8'h09);
    repeat (5) @(negedge clk);
    chk(flags == 2'b00, "R4", flags, 0);

    // R3: day-of-month sweep 1..31 vs 1..31
    for (int a = 1; a <= 31; a++) begin
      for (int t = 1; t <= 31; t++) begin
        al[3] = 8'(a); tm[3] = 8'(t);
        upd_pulse();
        e = {1'b1, (a == t)};
        chk(flags == e, "R3", flags, e);
        rd_pulse(e, "R8");
      end
    end

    // R6: single-field off-by-one mismatch
    for (int f = 0; f < 4; f++) begin
      set_all(8'h21, 8'h33, 8'h12, 8'h1F);
      tm[f] = tm[f] + 8'd1;
      upd_pulse();
      chk(flags == 2'b10, "R6", flags, 2'b10);
      rd_pulse(2'b10, "R8");
    end

    // R5: wildcard codes per field
    for (int f = 0; f < 4; f++) begin
      for (int c = 8'hC0; c <= 8'hFF; c++) begin
        set_all(8'h02, 8'h04, 8'h08, 8'h10);
        al[f] = 8'(c);
        tm[f] = 8'((c * 7) & 8'h3F);
        upd_pulse();
        e = {1'b1, exp_alarm()};
        chk(flags == 2'b11, "R5", flags, e);
        rd_pulse(2'b11, "R8");
      end
    end

    // R10: alarm flag sticks across a later mismatching update
    set_all(8'h45, 8'h59, 8'h23, 8'h1E);
    upd_pulse();
    chk(flags == 2'b11, "R10", flags, 2'b11);
    tm[0] = 8'h46;
    upd_pulse();
    chk(flags == 2'b11, "R10", flags, 2'b11);
    en = 2'b01; #1 chk(irq == 1'b1, "R7", irq, 1);
    rd_pulse(2'b11, "R10");
    chk(irq == 1'b0, "R8", irq, 0);

    // R9: read and update together
    upd_pulse();
    chk(flags == 2'b10, "R9", flags, 2'b10);
    tm[0] = 8'h45;
    @(negedge clk) begin upd = 1'b1; rd = 1'b1; end
    #1 chk(flags == 2'b10, "R9", flags, 2'b10);
    @(negedge clk) begin upd = 1'b0; rd = 1'b0; end
    chk(flags == 2'b11, "R9", flags, 2'b11);
    chk(irq == 1'b1, "R9", irq, 1);
    tm[0] = 8'h47;
    @(negedge clk) begin upd = 1'b1; rd = 1'b1; end
    @(negedge clk) begin upd = 1'b0; rd = 1'b0; end
    chk(flags == 2'b10, "R9", flags, 2'b10);
    rd_pulse(2'b10, "R8");

    finish_run();
  end
endmodule